// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block keeps the interrupt bookkeeping for a five-channel DMA engine. It tracks five event classes: whole transfer done, block done, source transaction done, destination transaction done, and error. For each class it holds one latched event bit per channel and one enable (mask) bit per channel. The masked view is the latched bit ANDed with the enable bit. A per-class summary word reports which classes have any masked event pending. A single registered interrupt line combines every masked event, gated by a per-channel global interrupt enable.

The DMA core drives one single-cycle pulse per channel and class. Software reaches the block through a simple write port and a combinational read port. The address is five bits. Bits [4:3] select the register kind: 0 latched, 1 enable, 2 masked view, 3 clear. Bits [2:0] select the class: 0 transfer, 1 block, 2 source, 3 destination, 4 error. Enable writes carry a per-channel write-enable field in bits [12:8], so software can change single enable bits without reading them first. Clear writes are write-one-to-clear.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every latched bit, enable bit, masked bit, summary bit and the interrupt output is 0.
- R2: An event pulse on channel c of class t sets latched bit c of class t at the next clock edge. This happens whatever the enable bit and the channel's global interrupt enable are.
- R3: Reading kind 2 with class t (address {2'b10, t}) returns, in bits [4:0], the latched bits of class t ANDed with its enable bits. Bits [15:5] read 0.
- R4: A write to kind 1 updates enable bit c of the class to data bit c only when data bit 8+c is 1. Enable bits whose write-enable bit is 0 keep their value.
- R5: A write to kind 3 clears latched bit c of the class, and with it the masked bit, wherever data bit c is 1. Data bits that are 0 have no effect. Any read of kind 3 returns 0.
- R6: When an event pulse and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R7: A write to kind 0 loads the class's latched bits with data bits [4:0]. An event pulse in the same cycle still sets its bit.
- R8: Reading address 5'b10111 returns the summary word. Bit t is the OR of the masked bits of class t across all channels (bit 0 transfer up to bit 4 error). Bits [15:5] read 0.
- R9: The interrupt output goes to 1 at the clock edge that follows a cycle in which some masked bit of channel c is 1 and global enable c is 1. Otherwise it goes to 0 at that edge.
- R10: Class selectors 5 to 7 under kinds 0, 1 and 3 read 0 and have no effect when written. Under kind 2, selectors 5 and 6 read 0. Writes to kind 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 25 | Event pulses, bit t*5+c is class t, channel c |
| ch_int_en_i | input | 5 | Per-channel global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address {kind, class} |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 5 | Read address {kind, class} |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Event pulses and register writes change the latched and enable bits at the edge that samples them. The combinational read port shows the new value one time step after that edge, with no further delay. The interrupt output lags the masked state by one more edge, because it registers the masked bits and enables that were present before the edge. The bench drives each cycle's stimulus between edges and steps a reference model once per edge. It predicts the interrupt from the pre-edge model state and the enables driven in that cycle. After each edge it sweeps all 32 read addresses, and it compares the interrupt line in the same window.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NCH    = 5;
    localparam int NTYPE  = 5;
    localparam int DW     = 16;
    localparam int AW     = 5;
    localparam int WE_LSB = 8;

    typedef enum logic [1:0] {
        KIND_RAW  = 2'd0,
        KIND_MASK = 2'd1,
        KIND_STAT = 2'd2,
        KIND_CLR  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/dma_irq_type_bank.sv
module dma_irq_type_bank #(
    parameter int NCH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic           raw_wr_i,
    input  logic           mask_wr_i,
    input  logic           clr_wr_i,
    input  logic [NCH-1:0] wval_i,
    input  logic [NCH-1:0] wen_i,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] status_o
);
    typedef struct packed {
        logic [NCH-1:0] raw;
        logic [NCH-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_wr_i) begin
            st_d.raw = wval_i;
        end
        if (clr_wr_i) begin
            st_d.raw = st_d.raw & ~wval_i;
        end
        // a pulse always lands, even against a clear in the same cycle
        st_d.raw = st_d.raw | evt_i;
        if (mask_wr_i) begin
            st_d.mask = (st_q.mask & ~wen_i) | (wval_i & wen_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o    = st_q.raw;
    assign mask_o   = st_q.mask;
    assign status_o = st_q.raw & st_q.mask;

    // R2 R6
    evt_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

    // R4
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_wr_i) |=> (mask_o == $past(mask_o)));

    // R4
    mask_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (((mask_o ^ $past(mask_o)) & ~$past(wen_i)) == '0));

    // R5
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((raw_o & $past(wval_i & ~evt_i)) == '0));

    // R7
    raw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_wr_i |=> ((raw_o & ~$past(evt_i)) == ($past(wval_i) & ~$past(evt_i))));
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine #(
    parameter int NCH   = 5,
    parameter int NTYPE = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTYPE*NCH-1:0] status_i,
    input  logic [NCH-1:0]       ch_en_i,
    output logic [NTYPE-1:0]     summary_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic irq;
    } comb_t;

    comb_t          st_d, st_q;
    logic [NCH-1:0] any_per_ch;

    always_comb begin
        any_per_ch = '0;
        summary_o  = '0;
        for (int t = 0; t < NTYPE; t++) begin
            summary_o[t] = |status_i[t*NCH +: NCH];
            any_per_ch   = any_per_ch | status_i[t*NCH +: NCH];
        end
        st_d.irq = |(any_per_ch & ch_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> !irq_o);
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NCH_P   = NCH,
    parameter int NTYPE_P = NTYPE,
    parameter int DW_P    = DW,
    parameter int AW_P    = AW,
    parameter int WEL_P   = WE_LSB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTYPE_P*NCH_P-1:0] evt_i,
    input  logic [NCH_P-1:0]         ch_int_en_i,
    input  logic                     wr_en_i,
    input  logic [AW_P-1:0]          wr_addr_i,
    input  logic [DW_P-1:0]          wr_data_i,
    input  logic [AW_P-1:0]          rd_addr_i,
    output logic [DW_P-1:0]          rd_data_o,
    output logic                     irq_o
);
    localparam int TSEL_W = AW_P - 2;
    localparam logic [TSEL_W-1:0] SUM_SEL = '1;

    logic [1:0]        wr_kind, rd_kind;
    logic [TSEL_W-1:0] wr_sel, rd_sel;
    logic [NCH_P-1:0]  raw_arr  [NTYPE_P];
    logic [NCH_P-1:0]  mask_arr [NTYPE_P];
    logic [NTYPE_P*NCH_P-1:0] status_flat;
    logic [NTYPE_P-1:0] summary;
    logic wr_data_unused;

    assign wr_kind = wr_addr_i[AW_P-1 -: 2];
    assign wr_sel  = wr_addr_i[TSEL_W-1:0];
    assign rd_kind = rd_addr_i[AW_P-1 -: 2];
    assign rd_sel  = rd_addr_i[TSEL_W-1:0];
    assign wr_data_unused = ^wr_data_i;

    for (genvar t = 0; t < NTYPE_P; t++) begin : g_bank
        logic hit;
        assign hit = wr_en_i && (wr_sel == TSEL_W'(t));
        dma_irq_type_bank #(.NCH(NCH_P)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[t*NCH_P +: NCH_P]),
            .raw_wr_i (hit && (wr_kind == KIND_RAW)),
            .mask_wr_i(hit && (wr_kind == KIND_MASK)),
            .clr_wr_i (hit && (wr_kind == KIND_CLR)),
            .wval_i   (wr_data_i[NCH_P-1:0]),
            .wen_i    (wr_data_i[WEL_P +: NCH_P]),
            .raw_o    (raw_arr[t]),
            .mask_o   (mask_arr[t]),
            .status_o (status_flat[t*NCH_P +: NCH_P])
        );
    end

    dma_irq_combine #(.NCH(NCH_P), .NTYPE(NTYPE_P)) u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_flat),
        .ch_en_i  (ch_int_en_i),
        .summary_o(summary),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_sel < TSEL_W'(NTYPE_P)) begin
            case (rd_kind)
                KIND_RAW:  rd_data_o[NCH_P-1:0] = raw_arr[rd_sel];
                KIND_MASK: rd_data_o[NCH_P-1:0] = mask_arr[rd_sel];
                KIND_STAT: rd_data_o[NCH_P-1:0] = raw_arr[rd_sel] & mask_arr[rd_sel];
                default:   rd_data_o = '0;
            endcase
        end else if (rd_kind == KIND_STAT && rd_sel == SUM_SEL) begin
            rd_data_o[NTYPE_P-1:0] = summary;
        end
    end

    // R8
    summary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flat == '0) |-> (summary == '0));
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
    localparam int CLK_PERIOD = 100;
    localparam int NC = 5;
    localparam int NT = 5;
    localparam int MAX_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT*NC-1:0] evt = '0;
    logic [NC-1:0] ch_en = '0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [NC-1:0] m_raw [NT];
    logic [NC-1:0] m_mask [NT];
    logic m_irq;

    dma_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ch_int_en_i(ch_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, MAX_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        logic [15:0] v = '0;
        int k = int'(a[4:3]);
        int s = int'(a[2:0]);
        if (s < NT) begin
            if (k == 0) v[NC-1:0] = m_raw[s];
            else if (k == 1) v[NC-1:0] = m_mask[s];
            else if (k == 2) v[NC-1:0] = m_raw[s] & m_mask[s];
        end else if (k == 2 && s == 7) begin
            for (int t = 0; t < NT; t++) v[t] = |(m_raw[t] & m_mask[t]);
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[2:0] > 3'd4 && a != 5'b10111) return "R10 unused select";
        case (a[4:3])
            2'd0: return "R2/R7 latched";
            2'd1: return "R4 enable";
            2'd2: return (a[2:0] == 3'd7) ? "R8 summary" : "R3 masked";
            default: return "R5 clear reads zero";
        endcase
    endfunction

    function automatic logic model_irq(input logic [NC-1:0] en);
        logic [NC-1:0] any = '0;
        for (int t = 0; t < NT; t++) any = any | (m_raw[t] & m_mask[t]);
        return |(any & en);
    endfunction

    task automatic model_step(input logic [NT*NC-1:0] e, input logic w,
                              input logic [4:0] a, input logic [15:0] d,
                              input logic [NC-1:0] en);
        m_irq = model_irq(en);
        for (int t = 0; t < NT; t++) begin
            if (w && a[2:0] == 3'(t)) begin
                if (a[4:3] == 2'd0) m_raw[t] = d[NC-1:0];
                if (a[4:3] == 2'd3) m_raw[t] = m_raw[t] & ~d[NC-1:0];
                if (a[4:3] == 2'd1)
                    m_mask[t] = (m_mask[t] & ~d[8 +: NC]) | (d[NC-1:0] & d[8 +: NC]);
            end
            m_raw[t] = m_raw[t] | e[t*NC +: NC];
        end
    endtask

    task automatic step(input logic [NT*NC-1:0] e, input logic w,
                        input logic [4:0] a, input logic [15:0] d,
                        input logic [NC-1:0] en);
        evt = e; wr_en = w; wr_addr = a; wr_data = d; ch_en = en;
        @(posedge clk);
        model_step(e, w, a, d, en);
        #1;
        evt = '0; wr_en = 1'b0;
    endtask

    task automatic check_all(input string pre);
        for (int i = 0; i < 32; i++) begin
            rd_addr = 5'(i);
            #1;
            chk({pre, tag_of(5'(i))}, rd_data, exp_read(5'(i)));
        end
        chk({pre, "R9 irq"}, {15'd0, irq}, {15'd0, m_irq});
    endtask

    function automatic logic [4:0] addr(input int k, input int s);
        return {2'(k), 3'(s)};
    endfunction

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        for (int t = 0; t < NT; t++) begin m_raw[t] = '0; m_mask[t] = '0; end
        m_irq = 1'b0;
        #(CLK_PERIOD*2 + 7);
        check_all("R1 reset ");
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: event with enable and global enable low still latches
        step(25'h0000004, 1'b0, '0, '0, 5'h00);
        rd(addr(0, 0), v); chk("R2 raw set while masked", v, 16'h0004);
        rd(addr(2, 0), v); chk("R3 masked view zero", v, 16'h0000);
        check_all("");

        // R4: partial enable write, then write with no enables
        step('0, 1'b1, addr(1, 0), 16'h0504, 5'h00);
        rd(addr(1, 0), v); chk("R4 enable partial", v, 16'h0004);
        step('0, 1'b1, addr(1, 0), 16'h0003, 5'h00);
        rd(addr(1, 0), v); chk("R4 enable held", v, 16'h0004);
        rd(addr(2, 0), v); chk("R3 masked view", v, 16'h0004);
        rd(5'b10111, v); chk("R8 summary", v, 16'h0001);
        chk("R9 irq off when global enable low", {15'd0, irq}, 16'h0000);

        // R9: one edge after enable goes high
        step('0, 1'b0, '0, '0, 5'h04);
        chk("R9 irq rises", {15'd0, irq}, 16'h0001);

        // R6: clear collides with event
        step(25'h0000004, 1'b1, addr(3, 0), 16'h001F, 5'h04);
        rd(addr(0, 0), v); chk("R6 event beats clear", v, 16'h0004);

        // R5: clear alone
        step('0, 1'b1, addr(3, 0), 16'h0004, 5'h04);
        rd(addr(0, 0), v); chk("R5 cleared", v, 16'h0000);
        rd(addr(3, 0), v); chk("R5 clear reads zero", v, 16'h0000);
        chk("R9 irq still high from pre-edge state", {15'd0, irq}, 16'h0001);
        step('0, 1'b0, '0, '0, 5'h04);
        chk("R9 irq falls", {15'd0, irq}, 16'h0000);

        // R7 and R10
        step('0, 1'b1, addr(0, 4), 16'h00FF, 5'h1F);
        rd(addr(0, 4), v); chk("R7 latched load", v, 16'h001F);
        step('0, 1'b1, addr(2, 4), 16'h0000, 5'h1F);
        rd(addr(0, 4), v); chk("R10 masked view write ignored", v, 16'h001F);
        step('0, 1'b1, addr(0, 6), 16'h001F, 5'h1F);
        rd(addr(0, 6), v); chk("R10 unused select reads zero", v, 16'h0000);
        check_all("");

        for (int n = 0; n < 2000; n++) begin
            logic [NT*NC-1:0] e;
            logic w;
            logic [4:0] a;
            e = 25'($urandom & $urandom & $urandom);
            w = ($urandom % 2) == 0;
            a = 5'($urandom);
            step(e, w, a, 16'($urandom), 5'($urandom));
            check_all("");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule